// File: doc/BRIEF.md
# UART FIFO Trigger and Interrupt Controller

This block holds the transmit and receive byte queues of a 16550-style serial port together with their pointers and fill counters. The host and the serial shifters move data through push and pop strobes. The block turns the fill levels into a transmit interrupt, a receive interrupt and two active-low ready outputs. The thresholds it uses come from a small programmed configuration: a FIFO control register, a feature control register and an enhanced feature register. All three share one write port, and the FIFO control register can be read back.

Two threshold tables are available. Both directions always use the same table, and the table is chosen by a 2-bit field in the feature control register. The receive interrupt follows the level upward through its threshold. The transmit interrupt fires when the level drops below its threshold or when the queue drains to empty. A host push into the transmit queue clears the transmit interrupt. A self-clearing flush command empties the transmit queue without touching anything downstream of it.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: With feature table field (feature control bits [5:4]) at 00, 10 or 11, the receive threshold for FIFO control bits [7:6] = 00/01/10/11 is 1/4/8/14 entries, and the transmit threshold is 1 whatever the value of bits [5:4].
- R2: With feature table field 01, the receive threshold for bits [7:6] = 00/01/10/11 is 8/16/24/28, and the transmit threshold for FIFO control bits [5:4] = 00/01/10/11 is 16/8/24/30.
- R3: A FIFO control write updates bits [5:4] only while enhanced feature bit 4 is 1. Otherwise those bits and the transmit threshold stay as they were, and the other fields of the same write still take effect.
- R4: The receive interrupt is 1 one cycle after the receive level is at or above the receive threshold, and 0 one cycle after the level is below it.
- R5: The transmit interrupt sets one cycle after the transmit level falls from at or above the threshold to below it. It also sets one cycle after the level falls from non-zero to zero. A host push into the transmit queue clears it.
- R6: A FIFO control write with bits 0 and 2 both 1 makes readback bit 2 read 1 until the next clock edge. At that edge the transmit level becomes 0, bit 2 returns to 0 and the receive queue is untouched. With bit 0 at 0, bit 2 does nothing.
- R7: FIFO control bit 3 selects the ready-output mode. In mode 0, tx_rdy_n is 0 while the transmit queue is empty and rx_rdy_n is 0 while the receive queue holds data. In mode 1, tx_rdy_n is 1 only while the transmit queue is full, and rx_rdy_n goes 0 at the receive threshold and returns to 1 only at empty. Both outputs follow the level with one cycle of delay.
- R8: Each queue holds DEPTH (32) bytes in first-in first-out order, shows its oldest byte on its read data output, and reports its level, which one push or pop changes at the same edge.
- R9: A push into a full queue or a pop from an empty queue is dropped, leaving the level unchanged, and sets fifo_err, which stays 1 until reset.
- R10: After reset the readback is 0, both levels are 0, both interrupts and fifo_err are 0, tx_rdy_n is 0 and rx_rdy_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 00 FIFO control, 01 feature control, 10 enhanced feature, 11 none |
| cfg_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | FIFO control register readback |
| tx_push | input | 1 | Host push into transmit queue |
| tx_wdata | input | DW | Transmit push data |
| tx_pop | input | 1 | Shifter pop from transmit queue |
| tx_rdata | output | DW | Oldest transmit byte |
| tx_level | output | $clog2(DEPTH)+1 | Transmit fill level |
| rx_push | input | 1 | Shifter push into receive queue |
| rx_wdata | input | DW | Receive push data |
| rx_pop | input | 1 | Host pop from receive queue |
| rx_rdata | output | DW | Oldest receive byte |
| rx_level | output | $clog2(DEPTH)+1 | Receive fill level |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_rdy_n | output | 1 | Transmit ready, active low |
| rx_rdy_n | output | 1 | Receive ready, active low |
| fifo_err | output | 1 | Sticky overflow/underflow flag |

## Verification
Register readback, levels, read data and fifo_err are all due at the same edge that samples the write, push or pop. The flush clears the level one edge after its write. Both interrupts and both ready outputs follow the level with one further edge of delay. The bench drives every strobe for a single cycle from the falling edge. It then samples at the next falling edge for the same-edge results, and waits one more falling edge before it reads the interrupts or the ready outputs. Each threshold in the table walk is probed on both sides of its boundary, at the level one step short of it and at the level that meets or crosses it.

// File: rtl/uft_pkg.sv
package uft_pkg;
   typedef enum logic [1:0] {
      SEL_FIFO_CTL = 2'b00,
      SEL_FEAT_CTL = 2'b01,
      SEL_ENH_FEAT = 2'b10,
      SEL_NONE     = 2'b11
   } cfg_sel_e;

   // FIFO control register image, MSB first
   typedef struct packed {
      logic [1:0] rx_fld;
      logic [1:0] tx_fld;
      logic       dma;
      logic       flush_pend;
      logic       rsv1;
      logic       en;
   } fifo_ctl_t;

   localparam int unsigned FEAT_TBL_LSB = 4;
   localparam int unsigned ENH_GATE_BIT = 4;
   localparam logic [1:0]  TBL_ALT      = 2'b01;
endpackage

// File: rtl/uft_regs.sv
module uft_regs
   import uft_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [1:0] cfg_sel,
   input  logic [7:0] cfg_wdata,
   output fifo_ctl_t  ctl_q,
   output logic [1:0] tbl_q,
   output logic       gate_q,
   output logic       tx_flush
);
   cfg_sel_e sel;
   logic     wr_ctl, wr_feat, wr_enh;

   assign sel     = cfg_sel_e'(cfg_sel);
   assign wr_ctl  = cfg_we && (sel == SEL_FIFO_CTL);
   assign wr_feat = cfg_we && (sel == SEL_FEAT_CTL);
   assign wr_enh  = cfg_we && (sel == SEL_ENH_FEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         tbl_q  <= 2'b00;
         gate_q <= 1'b0;
      end else begin
         ctl_q.flush_pend <= 1'b0;
         if (wr_ctl) begin
            ctl_q.rx_fld <= cfg_wdata[7:6];
            if (gate_q) begin
               ctl_q.tx_fld <= cfg_wdata[5:4];
            end
            ctl_q.dma        <= cfg_wdata[3];
            ctl_q.flush_pend <= cfg_wdata[2] & cfg_wdata[0];
            ctl_q.rsv1       <= cfg_wdata[1];
            ctl_q.en         <= cfg_wdata[0];
         end
         if (wr_feat) begin
            tbl_q <= cfg_wdata[FEAT_TBL_LSB +: 2];
         end
         if (wr_enh) begin
            gate_q <= cfg_wdata[ENH_GATE_BIT];
         end
      end
   end

   assign tx_flush = ctl_q.flush_pend;
endmodule

// File: rtl/uft_fifo.sv
module uft_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] level,
   output logic          drop
);
   if ((1 << AW) != DEPTH) begin : g_pow2_chk
      $error("uft_fifo: DEPTH must be a power of two");
   end
   if (DW < 1) begin : g_dw_chk
      $error("uft_fifo: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          full, empty, do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign drop    = (push && full) || (pop && empty);

   always_ff @(posedge clk) begin
      if (do_push && !flush) begin
         mem[wp] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   assign rdata = mem[rp];
   assign level = cnt;
endmodule

// File: rtl/uft_trig_map.sv
module uft_trig_map
   import uft_pkg::*;
#(
   parameter int LW           = 6,
   parameter bit ALT_TABLE_EN = 1'b1
) (
   input  logic [1:0]    tbl,
   input  logic [1:0]    rx_fld,
   input  logic [1:0]    tx_fld,
   output logic [LW-1:0] rx_thr,
   output logic [LW-1:0] tx_thr
);
   if (LW < 5) begin : g_lw_chk
      $error("uft_trig_map: LW too narrow for threshold 30");
   end

   logic [LW-1:0] rx_a, rx_b, tx_b;

   always_comb begin
      unique case (rx_fld)
         2'd0:    rx_a = LW'(1);
         2'd1:    rx_a = LW'(4);
         2'd2:    rx_a = LW'(8);
         default: rx_a = LW'(14);
      endcase
      unique case (rx_fld)
         2'd0:    rx_b = LW'(8);
         2'd1:    rx_b = LW'(16);
         2'd2:    rx_b = LW'(24);
         default: rx_b = LW'(28);
      endcase
      unique case (tx_fld)
         2'd0:    tx_b = LW'(16);
         2'd1:    tx_b = LW'(8);
         2'd2:    tx_b = LW'(24);
         default: tx_b = LW'(30);
      endcase
   end

   if (ALT_TABLE_EN) begin : g_two_tables
      logic use_b;
      assign use_b  = (tbl == TBL_ALT);
      assign rx_thr = use_b ? rx_b : rx_a;
      assign tx_thr = use_b ? tx_b : LW'(1);
   end else begin : g_base_table
      logic [1:0]    unused_tbl;
      logic [LW-1:0] unused_b;
      assign unused_tbl = tbl;
      assign unused_b   = rx_b ^ tx_b;
      assign rx_thr     = rx_a;
      assign tx_thr     = LW'(1);
   end
endmodule

// File: rtl/uft_irq.sv
module uft_irq #(
   parameter int DEPTH = 32,
   parameter int CW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] tx_cnt,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] tx_thr,
   input  logic [CW-1:0] rx_thr,
   input  logic          host_push,
   input  logic          dma,
   output logic          tx_irq,
   output logic          rx_irq,
   output logic          tx_rdy_n,
   output logic          rx_rdy_n
);
   logic [CW-1:0] tx_prev;
   logic          tx_fall, tx_drain, rx_hit;

   assign tx_fall  = (tx_cnt < tx_thr) && (tx_prev >= tx_thr);
   assign tx_drain = (tx_cnt == '0) && (tx_prev != '0);
   assign rx_hit   = (rx_cnt >= rx_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_prev  <= '0;
         tx_irq   <= 1'b0;
         rx_irq   <= 1'b0;
         tx_rdy_n <= 1'b0;
         rx_rdy_n <= 1'b1;
      end else begin
         tx_prev <= tx_cnt;
         tx_irq  <= tx_fall | tx_drain | (tx_irq & ~host_push);
         rx_irq  <= rx_hit;
         if (dma) begin
            tx_rdy_n <= (tx_cnt == CW'(DEPTH));
            if (rx_hit) begin
               rx_rdy_n <= 1'b0;
            end else if (rx_cnt == '0) begin
               rx_rdy_n <= 1'b1;
            end
         end else begin
            tx_rdy_n <= (tx_cnt != '0);
            rx_rdy_n <= (rx_cnt == '0);
         end
      end
   end
endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl
   import uft_pkg::*;
#(
   parameter int DW           = 8,
   parameter int DEPTH        = 32,
   parameter bit ALT_TABLE_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [1:0]               cfg_sel,
   input  logic [7:0]               cfg_wdata,
   output logic [7:0]               ctl_rdata,
   input  logic                     tx_push,
   input  logic [DW-1:0]            tx_wdata,
   input  logic                     tx_pop,
   output logic [DW-1:0]            tx_rdata,
   output logic [$clog2(DEPTH):0]   tx_level,
   input  logic                     rx_push,
   input  logic [DW-1:0]            rx_wdata,
   input  logic                     rx_pop,
   output logic [DW-1:0]            rx_rdata,
   output logic [$clog2(DEPTH):0]   rx_level,
   output logic                     tx_irq,
   output logic                     rx_irq,
   output logic                     tx_rdy_n,
   output logic                     rx_rdy_n,
   output logic                     fifo_err
);
   localparam int CW = $clog2(DEPTH) + 1;

   if (DEPTH < 32) begin : g_depth_chk
      $error("uart_fifo_trig_ctrl: DEPTH must cover the largest threshold");
   end

   fifo_ctl_t     ctl_q;
   logic [1:0]    tbl_q;
   logic          enh_gate;
   logic          tx_flush;
   logic [CW-1:0] tx_thr_w, rx_thr_w;
   logic          tx_drop, rx_drop;
   logic          err_q;

   uft_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .ctl_q     (ctl_q),
      .tbl_q     (tbl_q),
      .gate_q    (enh_gate),
      .tx_flush  (tx_flush)
   );

   uft_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (tx_flush),
      .push  (tx_push),
      .wdata (tx_wdata),
      .pop   (tx_pop),
      .rdata (tx_rdata),
      .level (tx_level),
      .drop  (tx_drop)
   );

   uft_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (1'b0),
      .push  (rx_push),
      .wdata (rx_wdata),
      .pop   (rx_pop),
      .rdata (rx_rdata),
      .level (rx_level),
      .drop  (rx_drop)
   );

   uft_trig_map #(.LW(CW), .ALT_TABLE_EN(ALT_TABLE_EN)) u_map (
      .tbl    (tbl_q),
      .rx_fld (ctl_q.rx_fld),
      .tx_fld (ctl_q.tx_fld),
      .rx_thr (rx_thr_w),
      .tx_thr (tx_thr_w)
   );

   uft_irq #(.DEPTH(DEPTH), .CW(CW)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_cnt    (tx_level),
      .rx_cnt    (rx_level),
      .tx_thr    (tx_thr_w),
      .rx_thr    (rx_thr_w),
      .host_push (tx_push),
      .dma       (ctl_q.dma),
      .tx_irq    (tx_irq),
      .rx_irq    (rx_irq),
      .tx_rdy_n  (tx_rdy_n),
      .rx_rdy_n  (rx_rdy_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (tx_drop || rx_drop) begin
         err_q <= 1'b1;
      end
   end

   assign fifo_err  = err_q;
   assign ctl_rdata = ctl_q;
endmodule

// File: rtl/uft_chk.sv
module uft_chk #(
   parameter int DEPTH = 32,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [1:0]    cfg_sel,
   input logic [7:0]    ctl_rdata,
   input logic [CW-1:0] tx_level,
   input logic [CW-1:0] rx_level,
   input logic          tx_irq,
   input logic          rx_irq,
   input logic          tx_rdy_n,
   input logic          fifo_err,
   input logic [CW-1:0] tx_thr,
   input logic [CW-1:0] rx_thr,
   input logic          enh_gate
);
   // R3: gated transmit field holds without the enhanced bit
   a_r3_tx_field_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'b00 && !enh_gate) |=> $stable(ctl_rdata[5:4]));

   a_r4_rx_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level >= rx_thr) |=> rx_irq);

   a_r4_rx_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level < rx_thr) |=> !rx_irq);

   a_r5_tx_irq_below: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_irq) |-> ($past(tx_level) < $past(tx_thr)));

   a_r6_flush_done: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[2] |=> (tx_level == '0 && !ctl_rdata[2]));

   a_r7_norm_tx_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[3] && tx_level == '0) |=> !tx_rdy_n);

   a_r8_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_err |=> fifo_err);
endmodule

bind uart_fifo_trig_ctrl uft_chk #(.DEPTH(DEPTH)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .ctl_rdata (ctl_rdata),
   .tx_level  (tx_level),
   .rx_level  (rx_level),
   .tx_irq    (tx_irq),
   .rx_irq    (rx_irq),
   .tx_rdy_n  (tx_rdy_n),
   .fifo_err  (fifo_err),
   .tx_thr    (tx_thr_w),
   .rx_thr    (rx_thr_w),
   .enh_gate  (enh_gate)
);

// File: tb/test_uart_fifo_trig_ctrl.sv
`timescale 1ns/1ps
module test_uart_fifo_trig_ctrl;
   localparam int DW    = 8;
   localparam int DEPTH = 32;
   localparam int CW    = $clog2(DEPTH) + 1;

   typedef struct packed {
      logic [1:0] tbl;
      logic [1:0] rxf;
      logic [1:0] txf;
      logic [7:0] rx_thr;
      logic [7:0] tx_thr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 2'b00, 2'b00, 8'd1,  8'd1},
      '{2'b00, 2'b01, 2'b11, 8'd4,  8'd1},
      '{2'b00, 2'b10, 2'b01, 8'd8,  8'd1},
      '{2'b00, 2'b11, 2'b10, 8'd14, 8'd1},
      '{2'b01, 2'b00, 2'b00, 8'd8,  8'd16},
      '{2'b01, 2'b01, 2'b01, 8'd16, 8'd8},
      '{2'b01, 2'b10, 2'b10, 8'd24, 8'd24},
      '{2'b01, 2'b11, 2'b11, 8'd28, 8'd30},
      '{2'b10, 2'b11, 2'b11, 8'd14, 8'd1},
      '{2'b11, 2'b01, 2'b10, 8'd4,  8'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = 2'b00;
   logic [7:0]    cfg_wdata = '0;
   logic [7:0]    ctl_rdata;
   logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [DW-1:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
   logic [CW-1:0] tx_level, rx_level;
   logic          tx_irq, rx_irq, tx_rdy_n, rx_rdy_n, fifo_err;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;

   uart_fifo_trig_ctrl #(.DW(DW), .DEPTH(DEPTH)) i_uart_fifo_trig_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .ctl_rdata(ctl_rdata),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
      .tx_rdata(tx_rdata), .tx_level(tx_level),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
      .rx_rdata(rx_rdata), .rx_level(rx_level),
      .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_rdy_n(tx_rdy_n),
      .rx_rdy_n(rx_rdy_n), .fifo_err(fifo_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
      cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push_tx(input logic [7:0] d);
      tx_wdata = d; tx_push = 1'b1;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic pop_tx();
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] d);
      rx_wdata = d; rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic pop_rx();
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic drain_all();
      while (tx_level != '0) pop_tx();
      while (rx_level != '0) pop_rx();
      idle(2);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   // receive threshold probe: one short of it, then at it
   task automatic rx_probe(input int thr, input string tag);
      for (int i = 0; i < thr - 1; i++) push_rx(8'(i));
      idle(1);
      chk({tag, " rx_irq below threshold"}, int'(rx_irq), 0);
      push_rx(8'hEE);
      idle(1);
      chk({tag, " rx_irq at threshold"}, int'(rx_irq), 1);
      while (rx_level != '0) pop_rx();
      idle(1);
   endtask

   // transmit threshold probe: fill to thr+1, step down through the threshold
   task automatic tx_probe(input int thr, input string tag);
      for (int i = 0; i < thr + 1; i++) push_tx(8'(i));
      idle(1);
      chk({tag, " R5 tx_irq after refill"}, int'(tx_irq), 0);
      pop_tx();
      idle(1);
      chk({tag, " tx_irq at threshold"}, int'(tx_irq), 0);
      pop_tx();
      idle(1);
      chk({tag, " tx_irq below threshold"}, int'(tx_irq), 1);
      while (tx_level != '0) pop_tx();
      idle(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R8 watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle(1);
      do_reset();

      // R10 reset state
      chk("R10 ctl_rdata", int'(ctl_rdata), 0);
      chk("R10 tx_level", int'(tx_level), 0);
      chk("R10 rx_level", int'(rx_level), 0);
      chk("R10 tx_irq", int'(tx_irq), 0);
      chk("R10 rx_irq", int'(rx_irq), 0);
      chk("R10 tx_rdy_n", int'(tx_rdy_n), 0);
      chk("R10 rx_rdy_n", int'(rx_rdy_n), 1);
      chk("R10 fifo_err", int'(fifo_err), 0);

      // table walk: R1 for fields 00/10/11, R2 for field 01
      for (int v = 0; v < NV; v++) begin
         cfg(2'b10, 8'h10);
         cfg(2'b01, {2'b00, VECS[v].tbl, 4'b0000});
         cfg(2'b00, {VECS[v].rxf, VECS[v].txf, 4'b0001});
         if (VECS[v].tbl == 2'b01) begin
            rx_probe(int'(VECS[v].rx_thr), "R2 R4");
            tx_probe(int'(VECS[v].tx_thr), "R2 R5");
         end else begin
            rx_probe(int'(VECS[v].rx_thr), "R1 R4");
            tx_probe(int'(VECS[v].tx_thr), "R1 R5");
         end
      end

      // R3 gated transmit field
      cfg(2'b01, 8'h10);
      cfg(2'b10, 8'h10);
      cfg(2'b00, 8'h11);
      chk("R3 tx field written while gate open", int'(ctl_rdata[5:4]), 1);
      cfg(2'b10, 8'h00);
      cfg(2'b00, 8'hB1);
      chk("R3 tx field kept while gate closed", int'(ctl_rdata[5:4]), 1);
      chk("R3 rx field still written", int'(ctl_rdata[7:6]), 2);
      tx_probe(8, "R3");

      // R6 flush
      cfg(2'b01, 8'h00);
      cfg(2'b00, 8'h01);
      for (int i = 0; i < 5; i++) push_tx(8'(i));
      for (int i = 0; i < 3; i++) push_rx(8'(i));
      idle(1);
      cfg(2'b00, 8'h05);
      chk("R6 flush bit reads 1", int'(ctl_rdata[2]), 1);
      chk("R6 level before flush edge", int'(tx_level), 5);
      idle(1);
      chk("R6 tx level cleared", int'(tx_level), 0);
      chk("R6 flush bit self-cleared", int'(ctl_rdata[2]), 0);
      chk("R6 rx untouched", int'(rx_level), 3);
      idle(1);
      chk("R5 tx_irq on flush drain", int'(tx_irq), 1);
      push_tx(8'h77);
      chk("R5 tx_irq cleared by push", int'(tx_irq), 0);
      push_tx(8'h78);
      cfg(2'b00, 8'h04);
      idle(1);
      chk("R6 no flush without enable", int'(tx_level), 2);
      chk("R6 bit 2 without enable", int'(ctl_rdata[2]), 0);
      drain_all();

      // R8 ordering on both queues
      cfg(2'b00, 8'h01);
      for (int k = 0; k < 6; k++) begin
         push_tx(8'(k * 37 + 5));
         push_rx(8'(k * 53 + 9));
      end
      chk("R8 tx level", int'(tx_level), 6);
      chk("R8 rx level", int'(rx_level), 6);
      for (int k = 0; k < 6; k++) begin
         chk("R8 tx order", int'(tx_rdata), (k * 37 + 5) % 256);
         chk("R8 rx order", int'(rx_rdata), (k * 53 + 9) % 256);
         pop_tx();
         pop_rx();
      end
      idle(2);

      // R7 ready outputs, normal mode
      chk("R7 normal tx_rdy_n empty", int'(tx_rdy_n), 0);
      chk("R7 normal rx_rdy_n empty", int'(rx_rdy_n), 1);
      push_tx(8'h01);
      push_rx(8'h02);
      idle(1);
      chk("R7 normal tx_rdy_n data", int'(tx_rdy_n), 1);
      chk("R7 normal rx_rdy_n data", int'(rx_rdy_n), 0);
      drain_all();

      // R7 DMA mode, table A receive threshold 4
      cfg(2'b00, 8'h49);
      idle(1);
      chk("R7 dma bit readback", int'(ctl_rdata[3]), 1);
      for (int i = 0; i < 3; i++) push_rx(8'(i));
      idle(1);
      chk("R7 dma rx_rdy_n below thr", int'(rx_rdy_n), 1);
      push_rx(8'h03);
      idle(1);
      chk("R7 dma rx_rdy_n at thr", int'(rx_rdy_n), 0);
      for (int i = 0; i < 3; i++) pop_rx();
      idle(1);
      chk("R7 dma rx_rdy_n held", int'(rx_rdy_n), 0);
      pop_rx();
      idle(1);
      chk("R7 dma rx_rdy_n empty", int'(rx_rdy_n), 1);
      chk("R7 dma tx_rdy_n empty", int'(tx_rdy_n), 0);
      for (int i = 0; i < DEPTH; i++) push_tx(8'(i));
      idle(1);
      chk("R7 dma tx_rdy_n full", int'(tx_rdy_n), 1);
      chk("R8 tx full level", int'(tx_level), DEPTH);
      chk("R9 no error yet", int'(fifo_err), 0);
      push_tx(8'hFF);
      chk("R9 overflow dropped", int'(tx_level), DEPTH);
      chk("R9 overflow flagged", int'(fifo_err), 1);
      pop_tx();
      idle(1);
      chk("R7 dma tx_rdy_n space", int'(tx_rdy_n), 0);
      chk("R9 error sticky", int'(fifo_err), 1);
      drain_all();

      // R9 underflow after fresh reset
      do_reset();
      chk("R10 fifo_err cleared", int'(fifo_err), 0);
      pop_rx();
      chk("R9 underflow level", int'(rx_level), 0);
      chk("R9 underflow flagged", int'(fifo_err), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule